// File: doc/BRIEF.md
# Serial Port Status Flag Register

This block holds the eight status and control flags of an asynchronous serial port. It sits between the transmit and receive shift logic and a CPU bus. The shift logic reports single-cycle events: a byte moved from the transmit buffer into the shifter, the last bit of a character went out, or a character finished with its stop-bit and parity check results. DMA strobes mark accesses to the data buffers. The block turns these events into flags and clears them by fixed rules.

Software clears an error or status flag in two steps. It first reads the register while the flag is 1. A later write of 0 to that bit then clears it. A write of 0 with no such read leaves the flag as it is. DMA accesses to the data buffers clear the matching buffer flag directly. Two conditions force the port into a safe state. A low transmit enable forces the transmit flags high. A standby level puts the register into its reset image.

Top module: `serstat_reg`

## Requirements
- R1: The bit layout is 7 transmit-buffer-empty, 6 receive-buffer-full, 5 overrun, 4 framing error, 3 parity error, 2 transmit-done, 1 received multiprocessor bit and 0 multiprocessor bit to send. `rdata` shows the register at all times. Reset forces 8'h84 asynchronously.
- R2: Bit 0 takes `wdata[0]` on every write (`cs`=1, `we`=1) and drives `tx_mpb`. Writes never change bits 2 and 1. Writing 1 to any of bits 7..3 has no effect.
- R3: A write with bit i of `wdata` at 0 clears flag i (7..3) only if a read (`cs`=1, `we`=0) saw that flag at 1 since it last became 1. The qualifier is kept per flag. It is dropped whenever the flag goes to 0 by any path.
- R4: `ev_tx_load` sets bit 7. Bit 7 is cleared by the R3 handshake or by `dma_tx_wr`.
- R5: While `tx_en` is 0, bits 7 and 2 are 1 in the following cycle.
- R6: `ev_tx_last` sets bit 2 only when bit 7 is 1. It is ignored otherwise. Bit 2 goes to 0 in the same cycle as any clear of bit 7.
- R7: `ev_rx_done` with both error inputs low and bit 6 at 0 sets bit 6 and copies `rx_mpb` into bit 1. Bit 6 is cleared by the R3 handshake or by `dma_rx_rd`.
- R8: `ev_rx_done` while bit 6 is 1 sets bit 5. Bits 6 and 1 keep their values.
- R9: `ev_rx_done` with `rx_frm_err` sets bit 4. With `rx_par_err` it sets bit 3. In either case bits 6 and 1 are not updated.
- R10: While `standby` is 1, bits 7 and 2 become 1 and bits 6..3 become 0, as after reset. Bits 1 and 0 keep their values. All read qualifiers are dropped.
- R11: A set event in the same cycle as a clearing write or DMA clear wins, so the flag stays 1. Its read qualifier stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cs | input | 1 | Register access strobe |
| we | input | 1 | 1 = write, 0 = read, qualified by cs |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Current register contents |
| tx_en | input | 1 | Transmitter enable level |
| standby | input | 1 | Standby level |
| ev_tx_load | input | 1 | Transmit buffer moved to shifter |
| ev_tx_last | input | 1 | Last bit of a character sent |
| ev_rx_done | input | 1 | Received character complete |
| rx_frm_err | input | 1 | Stop bit sampled as 0, valid with ev_rx_done |
| rx_par_err | input | 1 | Parity mismatch, valid with ev_rx_done |
| rx_mpb | input | 1 | Received multiprocessor bit, valid with ev_rx_done |
| dma_tx_wr | input | 1 | DMA wrote the transmit buffer |
| dma_rx_rd | input | 1 | DMA read the receive buffer |
| tx_mpb | output | 1 | Multiprocessor bit to transmit |

## Verification
The clear handshake is tried three ways: a write of 0 with no prior read, a read followed by a write, and a read followed by an intervening DMA clear or standby before the write. The first case tells an unqualified clear apart from a guarded one. The last case shows whether the qualifier is dropped when the flag falls by another path. The receive events are fed as a clean character, a character on a full buffer, and characters with framing or parity faults, which separates the overrun path from the normal transfer. Same-cycle collisions of set events with clears, and `ev_tx_last` with bit 7 at 0 and at 1, pin down the priority rules.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
  localparam int SR_W   = 8;
  localparam int B_TDRE = 7;
  localparam int B_RDRF = 6;
  localparam int B_OVR  = 5;
  localparam int B_FRM  = 4;
  localparam int B_PAR  = 3;
  localparam int B_TEND = 2;
  localparam int B_MPBR = 1;
  localparam int B_MPBT = 0;
  // clearable flags occupy bits CLR_LO .. SR_W-1
  localparam int CLR_LO = B_PAR;
  localparam int NCLR   = SR_W - CLR_LO;
  localparam logic [SR_W-1:0] RST_IMG = 8'h84;
endpackage

// File: rtl/serstat_flag.sv
// One clearable flag: next-state logic plus its read-seen-one qualifier.
module serstat_flag #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic standby_i,
  input  logic q_i,
  input  logic set_i,
  input  logic dma_clr_i,
  input  logic rd_i,
  input  logic wr0_i,
  output logic d_o
);
  logic arm_q;
  logic arm_d;
  logic clr;

  always_comb begin
    clr = (wr0_i && arm_q) || dma_clr_i;
    if (standby_i)   d_o = RST_VAL;
    else if (set_i)  d_o = 1'b1;
    else if (clr)    d_o = 1'b0;
    else             d_o = q_i;
  end

  always_comb begin
    if (standby_i || !d_o) arm_d = 1'b0;
    else                   arm_d = arm_q || (rd_i && q_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= 1'b0;
    else        arm_q <= arm_d;
  end
endmodule

// File: rtl/serstat_rxev.sv
// Decodes a finished character into flag set requests.
module serstat_rxev (
  input  logic done_i,
  input  logic frm_i,
  input  logic par_i,
  input  logic full_i,
  output logic set_full_o,
  output logic set_ovr_o,
  output logic set_frm_o,
  output logic set_par_o
);
  always_comb begin
    set_ovr_o  = done_i && full_i;
    set_frm_o  = done_i && frm_i;
    set_par_o  = done_i && par_i;
    set_full_o = done_i && !full_i && !frm_i && !par_i;
  end
endmodule

// File: rtl/serstat_tend.sv
// Transmit-done flag next state.
module serstat_tend (
  input  logic tx_en_i,
  input  logic standby_i,
  input  logic last_i,
  input  logic empty_q_i,
  input  logic empty_d_i,
  input  logic q_i,
  output logic d_o
);
  logic force_set;
  logic empty_fall;

  always_comb begin
    force_set  = standby_i || !tx_en_i || (last_i && empty_q_i);
    empty_fall = empty_q_i && !empty_d_i;
    if (force_set)       d_o = 1'b1;
    else if (empty_fall) d_o = 1'b0;
    else                 d_o = q_i;
  end
endmodule

// File: rtl/serstat_bus.sv
// Bus strobe decode.
module serstat_bus #(
  parameter int NCLR = 5
) (
  input  logic            cs_i,
  input  logic            we_i,
  input  logic [NCLR-1:0] wd_clr_i,
  output logic            rd_o,
  output logic            wr_o,
  output logic [NCLR-1:0] wr0_o
);
  always_comb begin
    rd_o  = cs_i && !we_i;
    wr_o  = cs_i && we_i;
    wr0_o = wr_o ? ~wd_clr_i : '0;
  end
endmodule

// File: rtl/serstat_reg.sv
module serstat_reg
  import serstat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cs,
  input  logic            we,
  input  logic [SR_W-1:0] wdata,
  output logic [SR_W-1:0] rdata,
  input  logic            tx_en,
  input  logic            standby,
  input  logic            ev_tx_load,
  input  logic            ev_tx_last,
  input  logic            ev_rx_done,
  input  logic            rx_frm_err,
  input  logic            rx_par_err,
  input  logic            rx_mpb,
  input  logic            dma_tx_wr,
  input  logic            dma_rx_rd,
  output logic            tx_mpb
);
  logic [1:0]      rst_pipe;
  logic            rst_sn;
  logic [SR_W-1:0] sr_q;
  logic [SR_W-1:0] sr_d;
  logic [NCLR-1:0] flag_d;
  logic [NCLR-1:0] set_vec;
  logic [NCLR-1:0] dma_vec;
  logic [NCLR-1:0] wr0;
  logic            bus_rd;
  logic            bus_wr;
  logic            set_full, set_ovr, set_frm, set_par;
  logic            tend_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  serstat_bus #(.NCLR(NCLR)) u_bus (
    .cs_i     (cs),
    .we_i     (we),
    .wd_clr_i (wdata[SR_W-1:CLR_LO]),
    .rd_o     (bus_rd),
    .wr_o     (bus_wr),
    .wr0_o    (wr0)
  );

  serstat_rxev u_rxev (
    .done_i     (ev_rx_done),
    .frm_i      (rx_frm_err),
    .par_i      (rx_par_err),
    .full_i     (sr_q[B_RDRF]),
    .set_full_o (set_full),
    .set_ovr_o  (set_ovr),
    .set_frm_o  (set_frm),
    .set_par_o  (set_par)
  );

  always_comb begin
    set_vec = '0;
    dma_vec = '0;
    set_vec[B_TDRE-CLR_LO] = ev_tx_load || !tx_en;
    set_vec[B_RDRF-CLR_LO] = set_full;
    set_vec[B_OVR-CLR_LO]  = set_ovr;
    set_vec[B_FRM-CLR_LO]  = set_frm;
    set_vec[B_PAR-CLR_LO]  = set_par;
    dma_vec[B_TDRE-CLR_LO] = dma_tx_wr;
    dma_vec[B_RDRF-CLR_LO] = dma_rx_rd;
  end

  for (genvar j = 0; j < NCLR; j++) begin : g_flag
    serstat_flag #(.RST_VAL(RST_IMG[j+CLR_LO])) u_flag (
      .clk       (clk),
      .rst_n     (rst_sn),
      .standby_i (standby),
      .q_i       (sr_q[j+CLR_LO]),
      .set_i     (set_vec[j]),
      .dma_clr_i (dma_vec[j]),
      .rd_i      (bus_rd),
      .wr0_i     (wr0[j]),
      .d_o       (flag_d[j])
    );
  end

  serstat_tend u_tend (
    .tx_en_i   (tx_en),
    .standby_i (standby),
    .last_i    (ev_tx_last),
    .empty_q_i (sr_q[B_TDRE]),
    .empty_d_i (flag_d[B_TDRE-CLR_LO]),
    .q_i       (sr_q[B_TEND]),
    .d_o       (tend_d)
  );

  always_comb begin
    sr_d                   = sr_q;
    sr_d[SR_W-1:CLR_LO]    = flag_d;
    sr_d[B_TEND]           = tend_d;
    if (set_full) sr_d[B_MPBR] = rx_mpb;
    if (bus_wr)   sr_d[B_MPBT] = wdata[B_MPBT];
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) sr_q <= RST_IMG;
    else         sr_q <= sr_d;
  end

  assign rdata  = sr_q;
  assign tx_mpb = sr_q[B_MPBT];
endmodule

// File: rtl/serstat_chk.sv
module serstat_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs,
  input logic       we,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       tx_en,
  input logic       standby,
  input logic       ev_rx_done,
  input logic       dma_tx_wr,
  input logic       dma_rx_rd
);
  // R5
  a_r5_txoff_forces: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |=> (rdata[7] && rdata[2]));

  // R10
  a_r10_standby_image: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> (rdata[7:2] == 6'b100001));

  // R6
  a_r6_tend_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[2]) |-> ($past(rdata[7]) || $past(!tx_en) || $past(standby)));

  // R7
  a_r7_full_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[6]) |-> $past(ev_rx_done));

  // R8
  a_r8_ovr_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdata[5]) |-> ($past(ev_rx_done) && $past(rdata[6])));

  // R3
  a_r3_ovr_clear_path: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdata[5]) |-> ($past(cs && we && !wdata[5]) || $past(standby)));

  // R2
  a_r2_mpbt_rw: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we) |=> (rdata[0] == $past(wdata[0])));

  // R2
  a_r2_ones_harmless: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && (wdata[7:1] == 7'h7F) && tx_en && !standby && !dma_tx_wr &&
     !dma_rx_rd && !ev_rx_done)
    |=> ((rdata[7:1] & $past(rdata[7:1])) == $past(rdata[7:1])));
endmodule

bind serstat_reg serstat_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sn),
  .cs         (cs),
  .we         (we),
  .wdata      (wdata),
  .rdata      (rdata),
  .tx_en      (tx_en),
  .standby    (standby),
  .ev_rx_done (ev_rx_done),
  .dma_tx_wr  (dma_tx_wr),
  .dma_rx_rd  (dma_rx_rd)
);

// File: tb/tb_serstat_reg.sv
`timescale 1ns/1ps
module tb_serstat_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs, we;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tx_en, standby, ev_tx_load, ev_tx_last, ev_rx_done;
  logic       rx_frm_err, rx_par_err, rx_mpb, dma_tx_wr, dma_rx_rd;
  logic       tx_mpb;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done  = 1'b0;

  always #2 clk = ~clk;

  serstat_reg dut (
    .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .wdata(wdata), .rdata(rdata),
    .tx_en(tx_en), .standby(standby), .ev_tx_load(ev_tx_load),
    .ev_tx_last(ev_tx_last), .ev_rx_done(ev_rx_done), .rx_frm_err(rx_frm_err),
    .rx_par_err(rx_par_err), .rx_mpb(rx_mpb), .dma_tx_wr(dma_tx_wr),
    .dma_rx_rd(dma_rx_rd), .tx_mpb(tx_mpb)
  );

  typedef struct packed {
    logic       cs, we;
    logic [7:0] wd;
    logic       txen, stby, ld, last, rxd, fe, pe, mpb, dw, dr;
    logic [7:0] exp;
    logic [3:0] req;
  } vec_t;

  // each row: inputs for one cycle, register value after that edge
  localparam vec_t VT [24] = '{
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h84,4'd1},  // R1 idle
    '{1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h84,4'd3},  // R3 write 0 without read
    '{1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h84,4'd3},  // R3 read arms
    '{1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd3},  // R3/R6 clear
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h80,4'd4},  // R4 load
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h84,4'd6},  // R6 last, empty=1
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,8'h00,4'd4},  // R4 dma write
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h00,4'd6},  // R6 last, empty=0
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,8'h42,4'd7},  // R7 good char
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h62,4'd8},  // R8 overrun
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,8'h22,4'd7},  // R7 dma read
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,8'h32,4'd9},  // R9 framing
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,8'h3A,4'd9},  // R9 parity
    '{1'b1,1'b1,8'hFF,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h3B,4'd2},  // R2 ones
    '{1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h3B,4'd3},  // R3 read
    '{1'b1,1'b1,8'hEF,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h2B,4'd3},  // R3 single bit
    '{1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h02,4'd3},  // R3 rest
    '{1'b0,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h86,4'd5},  // R5 tx off
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h86,4'd5},  // R5 hold
    '{1'b1,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h86,4'd3},  // read
    '{1'b1,1'b1,8'h00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h86,4'd11}, // R11 set wins
    '{1'b1,1'b1,8'h00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h02,4'd11}, // R11 arm kept
    '{1'b0,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,8'h40,4'd7},  // R7 mpb 0
    '{1'b0,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,8'h84,4'd10}  // R10 standby
  };

  task automatic idle();
    cs = 0; we = 0; wdata = 8'h00; tx_en = 1; standby = 0; ev_tx_load = 0;
    ev_tx_last = 0; ev_rx_done = 0; rx_frm_err = 0; rx_par_err = 0;
    rx_mpb = 0; dma_tx_wr = 0; dma_rx_rd = 0;
  endtask

  task automatic check(input string tag, input logic [7:0] exp);
    n_chk++;
    if (rdata !== exp) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
    end
  endtask

  // drive at a falling edge, let one rising edge pass, sample at the next fall
  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v);
    cs = v.cs; we = v.we; wdata = v.wd; tx_en = v.txen; standby = v.stby;
    ev_tx_load = v.ld; ev_tx_last = v.last; ev_rx_done = v.rxd;
    rx_frm_err = v.fe; rx_par_err = v.pe; rx_mpb = v.mpb;
    dma_tx_wr = v.dw; dma_rx_rd = v.dr;
    cycle();
    n_chk++;
    if (rdata !== v.exp) begin
      n_bad++;
      $display("FAIL R%0d table: rdata=%h expected=%h", v.req, rdata, v.exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check("R1 value in reset", 8'h84);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 value after release", 8'h84);

    for (int i = 0; i < 24; i++) run_vec(VT[i]);
    idle();

    // R3: qualifier dropped when a DMA read clears the flag
    ev_rx_done = 1; cycle(); ev_rx_done = 0;               // 0xC4
    cs = 1; we = 0; cycle();                               // arms bit 6 and 7
    cs = 0; dma_rx_rd = 1; cycle(); dma_rx_rd = 0;         // 0x84
    ev_rx_done = 1; cycle(); ev_rx_done = 0;               // 0xC4
    cs = 1; we = 1; wdata = 8'h00; cycle(); idle();
    check("R3 stale qualifier after dma clear", 8'h40);

    // R10: standby drops qualifiers
    cs = 1; we = 0; cycle(); idle();                       // arms bit 6
    standby = 1; cycle(); standby = 0;
    check("R10 standby image", 8'h84);
    ev_rx_done = 1; cycle(); ev_rx_done = 0;
    check("R7 set after standby", 8'hC4);
    cs = 1; we = 1; wdata = 8'h00; cycle(); idle();
    check("R10 qualifier dropped by standby", 8'hC4);

    // R2: bits 2 and 1 ignore writes, tx_mpb follows bit 0
    cs = 1; we = 1; wdata = 8'hFB; cycle(); idle();
    check("R2 write 1 to bit 0", 8'hC5);
    n_chk++;
    if (tx_mpb !== 1'b1) begin
      n_bad++;
      $display("FAIL R2 tx_mpb=%b expected=1", tx_mpb);
    end

    // R1: asynchronous reset mid run
    @(negedge clk); rst_n = 0; #1;
    check("R1 async reset", 8'h84);
    @(negedge clk); rst_n = 1;
    repeat (4) @(negedge clk);
    check("R1 after second release", 8'h84);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule